// File: doc/BRIEF.md
# External Interrupt Pin Wake Detector

This block qualifies a bank of external interrupt request pins on the fast clock. Each pin first passes through a synchronizer. It then goes through a symmetric glitch filter: the filtered level takes a new value only after the synchronized pin has held that value for a run of consecutive samples. The run is longer in HALT than in the other power modes. Each pin selects one of four triggers on its filtered level: falling edge, rising edge, low level or high level. A qualified trigger sets a per-pin detect flag. When the pin is enabled, it also sets a per-pin request flag. Software clears both flags of a pin with a clear strobe.

The OR of the request flags drives the interrupt request. The wake request for the power manager depends on the current power mode. In SLEEP any pending request wakes the device. In HALT and STOP only pins configured for a level trigger may wake it. In normal run mode there is no wake request. The filter counts fast-clock samples. The minimum pulse width, counted in slow system clocks, therefore scales with the clock ratio without any ratio setting inside the block.

Top module: `ext_irq_wake`

## Requirements
- R1: The filtered level of a pin changes only after the synchronized pin has differed from it for RUN_SAMPLES consecutive clocks (10 by default) in run, SLEEP and STOP modes, or HALT_SAMPLES (22 by default) in HALT. A single sample equal to the filtered level restarts the count. A pulse shorter than the threshold therefore sets no flag, and a pulse of exactly the threshold does.
- R2: A pin that becomes active ahead of clock edge 0 shows its flag after clock edge SYNC_STAGES + threshold (edge 12 with the defaults), and not after edge 11.
- R3: Trigger codes per pin, in bits [2i+1:2i] of `trig_mode`, are 00 falling edge, 01 rising edge, 10 low level and 11 high level. An edge trigger fires only on a transition of the filtered level in its own direction. A level trigger fires while the filtered level matches.
- R4: Clearing a level-triggered pin whose filtered level is still active leaves its flag set. Clearing an edge-triggered pin leaves it clear until a new qualified edge arrives, even if the pin stays active.
- R5: A high bit i of `clr` clears both flags of pin i at the next clock edge, unless a qualified trigger occurs in that same cycle. In that case the flags stay set.
- R6: `det_flag[i]` sets on a qualified trigger whatever the enable. `req_flag[i]` sets only when `pin_en[i]` is high. `irq` is the OR of `req_flag`.
- R7: Power mode codes are 00 run, 01 SLEEP, 10 HALT and 11 STOP. In SLEEP, `wake` is high whenever any request flag is set, whatever the trigger type.
- R8: In HALT and STOP, `wake` is high only when a request flag is set on a level-triggered pin. In run mode `wake` is low.
- R9: While reset is asserted, all flags, `irq` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Raw external interrupt pins |
| trig_mode | input | 2*NUM_PINS | Per-pin trigger code |
| pin_en | input | NUM_PINS | Per-pin request enable |
| pwr_mode | input | 2 | Current power mode code |
| clr | input | NUM_PINS | Per-pin flag clear strobe |
| req_flag | output | NUM_PINS | Per-pin request flags |
| det_flag | output | NUM_PINS | Per-pin detect flags |
| irq | output | 1 | Interrupt request, OR of request flags |
| wake | output | 1 | Wake request to the power manager |

## Verification
The hardest case to reach is the exact filter boundary in each mode. Only a pin run of exactly the threshold length, with no restart sample inside it, separates a correct filter from one off by one. The stimulus sweeps the pulse width one clock at a time across and around the threshold in run, STOP and HALT modes, with long idle gaps so that each pulse starts from a settled filter. It also splits a pulse with one inactive sample to prove the count restarts. The mode-dependent wake rules are reached by leaving a flag pending and then changing only the power mode, so that `wake` alone shows the rule.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_SLEEP = 2'b01,
    PM_HALT  = 2'b10,
    PM_STOP  = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    TRG_FALL = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trig_e;

  // Number of consecutive samples the filter needs in a given mode.
  function automatic int unsigned sample_limit(pwr_mode_e m, int unsigned run_n,
                                               int unsigned halt_n);
    return (m == PM_HALT) ? halt_n : run_n;
  endfunction

  // Whether a pin with this trigger may wake the device in this mode.
  function automatic logic may_wake(pwr_mode_e m, trig_e t);
    case (m)
      PM_SLEEP:        return 1'b1;
      PM_HALT, PM_STOP: return t[1];
      default:         return 1'b0;
    endcase
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_in,
  input  logic [CNT_W-1:0] thr,
  output logic             filt,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             filt_prev;
  logic             differs;
  logic             run_done;

  assign differs  = (s_in != filt);
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign run_done = differs && (cnt_nxt >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      filt      <= 1'b0;
      filt_prev <= 1'b0;
    end else begin
      filt_prev <= filt;
      if (run_done) begin
        filt <= s_in;
        cnt  <= '0;
      end else if (differs) begin
        cnt <= cnt_nxt;
      end else begin
        cnt <= '0;
      end
    end
  end

  assign rise_evt = filt & ~filt_prev;
  assign fall_evt = ~filt & filt_prev;

  // R1: the filtered level moves only at the end of a full run
  a_r1_change_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(cnt_nxt) >= $past(thr)));

  // R1: a matching sample restarts the count
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (s_in == filt) |=> (cnt == '0));
endmodule

// File: rtl/ext_irq_qual.sv
module ext_irq_qual
  import ext_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  filt,
  input  logic  rise_evt,
  input  logic  fall_evt,
  input  trig_e trig,
  input  logic  en,
  input  logic  clr,
  output logic  hit,
  output logic  det,
  output logic  req
);
  always_comb begin
    case (trig)
      TRG_FALL: hit = fall_evt;
      TRG_RISE: hit = rise_evt;
      TRG_LOW:  hit = ~filt;
      default:  hit = filt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det <= 1'b0;
      req <= 1'b0;
    end else begin
      if (hit)      det <= 1'b1;
      else if (clr) det <= 1'b0;
      if (hit && en) req <= 1'b1;
      else if (clr)  req <= 1'b0;
    end
  end

  // R5: a clear without a same-cycle trigger empties both flags
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(hit)) |-> (!det && !req));

  // R6: the request flag needs the enable
  a_r6_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(en));

  // R6: a request never stands without its detect
  a_r6_req_implies_det: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> det);
endmodule

// File: rtl/ext_irq_wake.sv
module ext_irq_wake
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RUN_SAMPLES  = 10,
  parameter int unsigned HALT_SAMPLES = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [2*NUM_PINS-1:0] trig_mode,
  input  logic [NUM_PINS-1:0]   pin_en,
  input  logic [1:0]            pwr_mode,
  input  logic [NUM_PINS-1:0]   clr,
  output logic [NUM_PINS-1:0]   req_flag,
  output logic [NUM_PINS-1:0]   det_flag,
  output logic                  irq,
  output logic                  wake
);
  localparam int unsigned MAX_SAMPLES = max_u(RUN_SAMPLES, HALT_SAMPLES);
  localparam int unsigned CNT_W       = $clog2(MAX_SAMPLES + 1);

  pwr_mode_e            mode;
  logic [CNT_W-1:0]     thr;
  logic [NUM_PINS-1:0]  pin_s;
  logic [NUM_PINS-1:0]  filt;
  logic [NUM_PINS-1:0]  rise_evt;
  logic [NUM_PINS-1:0]  fall_evt;
  logic [NUM_PINS-1:0]  hit;
  logic [NUM_PINS-1:0]  wake_ok;
  logic [NUM_PINS-1:0]  level_mask;

  assign mode = pwr_mode_e'(pwr_mode);
  assign thr  = CNT_W'(sample_limit(mode, RUN_SAMPLES, HALT_SAMPLES));

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      trig_e trig_i;
      assign trig_i        = trig_e'(trig_mode[2*i +: 2]);
      assign level_mask[i] = trig_i[1];
      assign wake_ok[i]    = may_wake(mode, trig_i);

      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in[i]),
        .q_out (pin_s[i])
      );

      ext_irq_filter #(.CNT_W(CNT_W)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_in     (pin_s[i]),
        .thr      (thr),
        .filt     (filt[i]),
        .rise_evt (rise_evt[i]),
        .fall_evt (fall_evt[i])
      );

      ext_irq_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (filt[i]),
        .rise_evt (rise_evt[i]),
        .fall_evt (fall_evt[i]),
        .trig     (trig_i),
        .en       (pin_en[i]),
        .clr      (clr[i]),
        .hit      (hit[i]),
        .det      (det_flag[i]),
        .req      (req_flag[i])
      );
    end
  endgenerate

  assign irq  = |req_flag;
  assign wake = |(req_flag & wake_ok);

  // R8: run mode never requests a wake
  a_r8_run_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) |-> !wake);

  // R8: in HALT or STOP the wake comes from a level-triggered pin
  a_r8_level_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PM_HALT || mode == PM_STOP) && wake) |-> ((req_flag & level_mask) != '0));

  // R7: a wake always has a pending request behind it
  a_r7_wake_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);
endmodule

// File: tb/ext_irq_wake_test.sv
`timescale 1ns/1ps
module ext_irq_wake_test;
  localparam int N = 8;
  localparam int RUN_T = 10;
  localparam int HALT_T = 22;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   pin_in = '0;
  logic [2*N-1:0] trig_mode = {N{2'b01}};
  logic [N-1:0]   pin_en = '0;
  logic [1:0]     pwr_mode = 2'b00;
  logic [N-1:0]   clr = '0;
  logic [N-1:0]   req_flag, det_flag;
  logic           irq, wake;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_wake uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_mode(trig_mode),
    .pin_en(pin_en), .pwr_mode(pwr_mode), .clr(clr),
    .req_flag(req_flag), .det_flag(det_flag), .irq(irq), .wake(wake)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_trig(int p, logic [1:0] t);
    trig_mode[2*p +: 2] = t;
  endtask

  task automatic clear(logic [N-1:0] m);
    clr = m;
    tick(1);
    clr = '0;
  endtask

  task automatic pulse(int p, int w);
    pin_in[p] = 1'b1;
    tick(w);
    pin_in[p] = 1'b0;
  endtask

  // pulse width sweep on pin 0 (rising) against the mode threshold
  task automatic sweep(logic [1:0] m, int thr, int wlo, int whi, string tag);
    pwr_mode = m;
    for (int w = wlo; w <= whi; w++) begin
      tick(2 * thr + 10);
      clear(8'h01);
      pulse(0, w);
      tick(thr + 6);
      check($sformatf("%s width=%0d", tag, w), req_flag[0], (w >= thr));
    end
  endtask

  initial begin
    tick(3);
    // R9: reset state
    check("R9 req", |req_flag, 1'b0);
    check("R9 det", |det_flag, 1'b0);
    check("R9 irq", irq, 1'b0);
    check("R9 wake", wake, 1'b0);
    rst_n = 1'b1;
    tick(5);

    pin_en = 8'b1011_1111;

    // R1: width sweeps in run, STOP and HALT
    sweep(2'b00, RUN_T, 1, RUN_T + 2, "R1 run");
    sweep(2'b11, RUN_T, RUN_T - 2, RUN_T + 1, "R1 stop");
    sweep(2'b10, HALT_T, 1, HALT_T + 2, "R1 halt");
    check("R8 halt edge pin no wake", wake, 1'b0);

    // R1: one inactive sample restarts the run
    pwr_mode = 2'b00;
    tick(40);
    clear(8'h01);
    pulse(0, RUN_T - 1);
    tick(1);
    pulse(0, RUN_T - 1);
    tick(RUN_T + 6);
    check("R1 split pulse", req_flag[0], 1'b0);

    // R2: latency with a high-level pin
    set_trig(1, 2'b11);
    tick(5);
    clear(8'h02);
    pin_in[1] = 1'b1;
    tick(SYNC + RUN_T);
    check("R2 before edge", req_flag[1], 1'b0);
    tick(1);
    check("R2 at edge", req_flag[1], 1'b1);
    // R4: level still active survives clear
    clear(8'h02);
    check("R4 level re-set", req_flag[1], 1'b1);
    pin_in[1] = 1'b0;
    tick(RUN_T + 6);
    clear(8'h02);
    check("R3 high level inactive", req_flag[1], 1'b0);

    // R4: edge pin held active stays clear after clear
    pin_in[0] = 1'b1;
    tick(RUN_T + 6);
    check("R3 rise sets", req_flag[0], 1'b1);
    clear(8'h01);
    check("R5 clear", req_flag[0] | det_flag[0], 1'b0);
    tick(20);
    check("R4 edge stays clear", req_flag[0], 1'b0);
    pin_in[0] = 1'b0;
    tick(RUN_T + 6);
    check("R3 rise ignores fall", req_flag[0], 1'b0);

    // R3: falling trigger
    set_trig(4, 2'b00);
    pin_in[4] = 1'b1;
    tick(RUN_T + 6);
    clear(8'h10);
    tick(3);
    check("R3 fall ignores rise", req_flag[4], 1'b0);
    pin_in[4] = 1'b0;
    tick(RUN_T + 6);
    check("R3 fall sets", req_flag[4], 1'b1);

    // R3/R4: low level trigger
    set_trig(5, 2'b10);
    tick(2);
    check("R3 low level sets", req_flag[5], 1'b1);
    clear(8'h20);
    check("R4 low level re-set", req_flag[5], 1'b1);
    pin_in[5] = 1'b1;
    tick(RUN_T + 6);
    clear(8'h20);
    check("R3 low level inactive", req_flag[5], 1'b0);

    // R6: disabled pin detects but does not request
    clear('1);
    tick(2);
    pulse(6, RUN_T + 4);
    tick(RUN_T + 6);
    check("R6 det on disabled", det_flag[6], 1'b1);
    check("R6 no req on disabled", req_flag[6], 1'b0);
    check("R6 irq low", irq, 1'b0);
    clear('1);
    check("R6 irq cleared", irq, 1'b0);

    // R7/R8: wake rules
    pwr_mode = 2'b10;
    pulse(2, HALT_T + 6);
    tick(HALT_T + 6);
    check("R6 irq from edge pin", irq, 1'b1);
    check("R8 halt edge no wake", wake, 1'b0);
    pwr_mode = 2'b11;
    tick(1);
    check("R8 stop edge no wake", wake, 1'b0);
    pwr_mode = 2'b01;
    tick(1);
    check("R7 sleep edge wakes", wake, 1'b1);
    pwr_mode = 2'b00;
    tick(1);
    check("R8 run no wake", wake, 1'b0);
    tick(HALT_T + 6);
    clear('1);

    pwr_mode = 2'b11;
    set_trig(3, 2'b11);
    tick(2);
    check("R8 no pending no wake", wake, 1'b0);
    pulse(3, RUN_T);
    tick(RUN_T + 6);
    check("R8 stop level wakes", wake, 1'b1);
    pwr_mode = 2'b10;
    tick(1);
    check("R8 halt level wakes", wake, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule